// File: doc/BRIEF.md
# Low-Power Halt Sequencer

This block decides how a small microcontroller sleeps and how it wakes. When the core pulses a halt request, the sequencer reads the oscillator-interrupt enable bit. With the bit set it enters a light halt: the oscillator and real-time counter keep running, the CPU and peripheral clocks stop, and the interrupt mask is forced open. With the bit clear it enters a deep halt: the oscillator stops as well.

Waking from light halt on an interrupt is immediate. The CPU clock returns on the next cycle and the core services the interrupt. Waking from deep halt, or from any reset, holds the CPU clock off while a settle counter runs for 256 or 4096 oscillator cycles. The count is chosen by an option bit. After a wake from the real-time counter, a settle window of the same length stays open. If software clears the oscillator-interrupt enable inside that window, the CPU and peripheral clocks stop again until the window closes.

The block drives the CPU, peripheral and oscillator enables, a forced mask value, a watchdog-reset suppress flag, and a flag that tells the core whether to fetch the reset vector or service an interrupt.

Top module: `halt_seq_top`

## Requirements
- R1: A `halt_req` pulse sampled while running moves the block to light halt if `osc_irq_en` is 1, or to deep halt if it is 0. The effect is visible after that clock edge.
- R2: In light halt, `osc_en` is 1 and both `cpu_clk_en` and `periph_clk_en` are 0.
- R3: In light halt, `imask_force_en` is 1 and `imask_force_val` is 2'b10; in every other state both are 0. An `irq_pending` already set ends light halt one cycle after entry.
- R4: `wdg_suppress` is 1 exactly while the block is in light halt.
- R5: Light halt ends on `rtc_irq`, on `irq_pending`, or on any bit of `ext_irq` while `ext_wake_en` is 1. External lines are ignored while `ext_wake_en` is 0. After the wake edge, `cpu_clk_en` is 1 at once.
- R6: A wake caused by `rtc_irq` (which wins over other sources in the same cycle) opens a settle window of D cycles. D is 256 when `long_delay_sel` is 0 and 4096 when it is 1. The CPU keeps running through the window while `osc_irq_en` stays 1.
- R7: If `osc_irq_en` is 0 at an edge inside the window, before the D-th edge after the wake edge, the CPU and peripheral clocks turn off and `osc_en` stays 1. They turn back on at the D-th edge. When the window expiring and the clear fall on the same edge, the expiry wins.
- R8: In deep halt, `osc_en`, `cpu_clk_en` and `periph_clk_en` are all 0. Only an enabled external interrupt ends deep halt; `rtc_irq` and `irq_pending` are ignored.
- R9: After a deep-halt wake edge, `osc_en` is 1 at once and `cpu_clk_en` rises at the D-th edge. D is sampled from `long_delay_sel` at the wake edge only.
- R10: While `rst_n` is low, `osc_en` is 1 and both clock enables are 0. After release, `cpu_clk_en` rises at the (D+1)-th rising edge.
- R11: `halt_req` has no effect in light halt, in deep halt, or while a settle count or window runs.
- R12: `resume_vec` is 1 (fetch reset vector) after any reset. It becomes 0 (service interrupt) at every interrupt wake from either halt depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle halt request from the core |
| osc_irq_en | input | 1 | Oscillator-interrupt enable; picks halt depth |
| long_delay_sel | input | 1 | 0: 256-cycle settle, 1: 4096-cycle settle |
| rtc_irq | input | 1 | Real-time-counter interrupt |
| ext_irq | input | EXT_N | External interrupt lines |
| ext_wake_en | input | 1 | Allows external lines to wake the device |
| irq_pending | input | 1 | Some interrupt is already pending |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| imask_force_en | output | 1 | Override interrupt mask bits |
| imask_force_val | output | 2 | Forced mask value (2'b10 when overriding) |
| wdg_suppress | output | 1 | Blocks watchdog reset |
| resume_vec | output | 1 | 1: fetch reset vector, 0: service interrupt |

## Verification
The hardest collision is a late clear of the oscillator-interrupt enable on the very edge where the post-RTC settle window expires. Both "stop the CPU" and "return to run" are candidate next states on that edge. Randomised runs place the clear at offsets 1, D-1, D and random points in between. The bench predicts the CPU enable on every edge of the window from the offset alone. It requires the enable to stay high when the clear lands exactly at expiry. A second collision, a halt request together with a pending interrupt, must give exactly one cycle of light halt.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

  typedef enum logic [2:0] {
    HS_BOOT    = 3'd0,
    HS_RUN     = 3'd1,
    HS_LIGHT   = 3'd2,
    HS_DEEP    = 3'd3,
    HS_SETTLE  = 3'd4,
    HS_WINDOW  = 3'd5,
    HS_PARTIAL = 3'd6
  } hs_state_e;

  localparam logic [1:0] MASK_OPEN = 2'b10;

  // Number of oscillator cycles in one settle period.
  function automatic int unsigned settle_cycles(input logic long_sel,
                                                input int unsigned short_c,
                                                input int unsigned long_c);
    return long_sel ? long_c : short_c;
  endfunction

endpackage

// File: rtl/halt_wake_src.sv
module halt_wake_src #(
  parameter int EXT_N = 4
) (
  input  logic             rtc_irq,
  input  logic             irq_pending,
  input  logic [EXT_N-1:0] ext_irq,
  input  logic             ext_wake_en,
  output logic             wake_rtc,
  output logic             wake_other,
  output logic             wake_deep
);
  logic wake_ext;

  assign wake_ext   = ext_wake_en & (|ext_irq);
  assign wake_rtc   = rtc_irq;
  assign wake_other = irq_pending | wake_ext;
  // Deep halt has no running time base, so only external lines count.
  assign wake_deep  = wake_ext;
endmodule

// File: rtl/halt_settle_cnt.sv
module halt_settle_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (run && !zero) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/halt_seq_fsm.sv
module halt_seq_fsm
  import halt_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt_req,
  input  logic      osc_irq_en,
  input  logic      wake_rtc,
  input  logic      wake_other,
  input  logic      wake_deep,
  input  logic      cnt_zero,
  output hs_state_e state,
  output logic      cnt_load,
  output logic      resume_vec
);
  hs_state_e nxt;
  logic      irq_resume;

  always_comb begin
    nxt        = state;
    cnt_load   = 1'b0;
    irq_resume = 1'b0;
    unique case (state)
      HS_BOOT: begin
        nxt      = HS_SETTLE;
        cnt_load = 1'b1;
      end
      HS_RUN: begin
        if (halt_req) nxt = osc_irq_en ? HS_LIGHT : HS_DEEP;
      end
      HS_LIGHT: begin
        if (wake_rtc) begin
          nxt        = HS_WINDOW;
          cnt_load   = 1'b1;
          irq_resume = 1'b1;
        end else if (wake_other) begin
          nxt        = HS_RUN;
          irq_resume = 1'b1;
        end
      end
      HS_DEEP: begin
        if (wake_deep) begin
          nxt        = HS_SETTLE;
          cnt_load   = 1'b1;
          irq_resume = 1'b1;
        end
      end
      HS_SETTLE: begin
        if (cnt_zero) nxt = HS_RUN;
      end
      HS_WINDOW: begin
        if (cnt_zero)         nxt = HS_RUN;
        else if (!osc_irq_en) nxt = HS_PARTIAL;
      end
      HS_PARTIAL: begin
        if (cnt_zero) nxt = HS_RUN;
      end
      default: nxt = HS_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= HS_BOOT;
      resume_vec <= 1'b1;
    end else begin
      state <= nxt;
      if (irq_resume) resume_vec <= 1'b0;
    end
  end
endmodule

// File: rtl/halt_seq_top.sv
module halt_seq_top
  import halt_seq_pkg::*;
#(
  parameter int          EXT_N     = 4,
  parameter int unsigned SHORT_DLY = 256,
  parameter int unsigned LONG_DLY  = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             osc_irq_en,
  input  logic             long_delay_sel,
  input  logic             rtc_irq,
  input  logic [EXT_N-1:0] ext_irq,
  input  logic             ext_wake_en,
  input  logic             irq_pending,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             imask_force_en,
  output logic [1:0]       imask_force_val,
  output logic             wdg_suppress,
  output logic             resume_vec
);
  localparam int CNT_W = $clog2(LONG_DLY);

  hs_state_e        state;
  logic             wake_rtc, wake_other, wake_deep;
  logic             cnt_load, cnt_zero, cnt_run;
  logic [CNT_W-1:0] cnt, load_val;

  // Named state wires for the checker.
  logic in_run, in_light, in_deep, in_settle, in_window, in_partial;

  assign in_run     = (state == HS_RUN);
  assign in_light   = (state == HS_LIGHT);
  assign in_deep    = (state == HS_DEEP);
  assign in_settle  = (state == HS_SETTLE);
  assign in_window  = (state == HS_WINDOW);
  assign in_partial = (state == HS_PARTIAL);

  assign load_val = CNT_W'(settle_cycles(long_delay_sel, SHORT_DLY, LONG_DLY) - 1);
  assign cnt_run  = in_settle | in_window | in_partial;

  halt_wake_src #(.EXT_N(EXT_N)) u_wake (
    .rtc_irq     (rtc_irq),
    .irq_pending (irq_pending),
    .ext_irq     (ext_irq),
    .ext_wake_en (ext_wake_en),
    .wake_rtc    (wake_rtc),
    .wake_other  (wake_other),
    .wake_deep   (wake_deep)
  );

  halt_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (load_val),
    .run      (cnt_run),
    .cnt      (cnt),
    .zero     (cnt_zero)
  );

  halt_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_req   (halt_req),
    .osc_irq_en (osc_irq_en),
    .wake_rtc   (wake_rtc),
    .wake_other (wake_other),
    .wake_deep  (wake_deep),
    .cnt_zero   (cnt_zero),
    .state      (state),
    .cnt_load   (cnt_load),
    .resume_vec (resume_vec)
  );

  assign osc_en          = !in_deep;
  assign cpu_clk_en      = in_run | in_window;
  assign periph_clk_en   = in_run | in_window;
  assign imask_force_en  = in_light;
  assign imask_force_val = in_light ? MASK_OPEN : 2'b00;
  assign wdg_suppress    = in_light;
endmodule

// File: rtl/halt_seq_checker.sv
module halt_seq_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_req,
  input logic             osc_irq_en,
  input logic             rtc_irq,
  input logic             irq_pending,
  input logic             osc_en,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             imask_force_en,
  input logic [1:0]       imask_force_val,
  input logic             wdg_suppress,
  input logic             resume_vec,
  input logic             in_run,
  input logic             in_light,
  input logic             in_deep,
  input logic             in_settle,
  input logic             in_window,
  input logic             in_partial,
  input logic             wake_deep,
  input logic             cnt_zero,
  input logic [CNT_W-1:0] cnt
);
  p_light_pick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && halt_req && osc_irq_en |=> wdg_suppress && !cpu_clk_en);

  p_deep_pick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && halt_req && !osc_irq_en |=> !osc_en && !cpu_clk_en);

  p_light_clocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_light |-> osc_en && !cpu_clk_en && !periph_clk_en);

  p_mask_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_suppress |-> imask_force_en && imask_force_val == 2'b10);

  p_pending_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_light && !rtc_irq && irq_pending |=> cpu_clk_en && !resume_vec);

  p_late_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_window && !cnt_zero && !osc_irq_en |=> in_partial && osc_en && !cpu_clk_en);

  p_deep_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_deep |-> !osc_en && !cpu_clk_en && !periph_clk_en);

  p_settle_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_settle || in_partial) && !cnt_zero |=> cnt == $past(cnt) - 1'b1);

  p_halt_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_deep && halt_req && !wake_deep |=> in_deep);

  p_rtc_resume_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_light && rtc_irq |=> in_window && !resume_vec);
endmodule

bind halt_seq_top halt_seq_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/halt_seq_top_bench.sv
`timescale 1ns/1ps
module halt_seq_top_bench;
  localparam int EXT_N = 4;
  localparam int SHORT = 256;
  localparam int LONG  = 4096;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, halt_req, osc_irq_en, long_delay_sel, rtc_irq, ext_wake_en, irq_pending;
  logic [EXT_N-1:0] ext_irq;
  logic osc_en, cpu_clk_en, periph_clk_en, imask_force_en, wdg_suppress, resume_vec;
  logic [1:0] imask_force_val;

  int checks = 0;
  int fails  = 0;

  halt_seq_top u_halt_seq_top (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_irq_en(osc_irq_en),
    .long_delay_sel(long_delay_sel), .rtc_irq(rtc_irq), .ext_irq(ext_irq),
    .ext_wake_en(ext_wake_en), .irq_pending(irq_pending), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .imask_force_en(imask_force_en), .imask_force_val(imask_force_val),
    .wdg_suppress(wdg_suppress), .resume_vec(resume_vec)
  );

  function automatic int settle_len(input logic l);
    return l ? LONG : SHORT;
  endfunction

  // Expected CPU enable e edges after an RTC wake edge, clear sampled at edge j (0 = none).
  function automatic int win_cpu(input int e, input int j, input int d);
    if (e >= d) return 1;
    if (j != 0 && e >= j) return 0;
    return 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic count_to_cpu(output int n);
    n = 0;
    while (n < 10000) begin
      step();
      n++;
      if (cpu_clk_en) break;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; halt_req = 1'b0; osc_irq_en = 1'b0; long_delay_sel = 1'b0;
    rtc_irq = 1'b0; ext_irq = '0; ext_wake_en = 1'b0; irq_pending = 1'b0;
    repeat (3) step();
    check("R10 osc in reset", osc_en, 1);
    check("R10 cpu in reset", cpu_clk_en, 0);
    check("R10 periph in reset", periph_clk_en, 0);
    check("R12 resume after reset", resume_vec, 1);
    rst_n = 1'b1;
    count_to_cpu(n);
    check("R10 boot delay short", n, settle_len(1'b0) + 1);

    // Light halt entry
    osc_irq_en = 1'b1; halt_req = 1'b1; step(); halt_req = 1'b0;
    check("R1 light entry cpu", cpu_clk_en, 0);
    check("R2 light osc", osc_en, 1);
    check("R2 light periph", periph_clk_en, 0);
    check("R3 mask force", imask_force_en, 1);
    check("R3 mask value", imask_force_val, 2);
    check("R4 wdg suppress", wdg_suppress, 1);

    // External lines while disabled are ignored
    ext_irq = 4'b0101; ext_wake_en = 1'b0;
    repeat (5) step();
    check("R5 ext disabled", cpu_clk_en, 0);
    halt_req = 1'b1; step(); halt_req = 1'b0;
    check("R11 halt in light", wdg_suppress, 1);
    ext_wake_en = 1'b1; step();
    check("R5 ext wake cpu", cpu_clk_en, 1);
    check("R12 ext wake resume", resume_vec, 0);
    check("R4 wdg after wake", wdg_suppress, 0);
    check("R3 mask after wake", imask_force_en, 0);
    ext_irq = '0; ext_wake_en = 1'b0;

    // Halt request with an interrupt already pending
    irq_pending = 1'b1; halt_req = 1'b1; step(); halt_req = 1'b0;
    check("R3 pending entry", wdg_suppress, 1);
    step();
    check("R3 pending immediate wake", cpu_clk_en, 1);
    irq_pending = 1'b0;

    // Randomised light-halt wakes
    for (int it = 0; it < 24; it++) begin
      int kind, idle, j, pick;
      kind = $urandom_range(0, 3);
      osc_irq_en = 1'b1; halt_req = 1'b1; step(); halt_req = 1'b0;
      check("R1 random entry", wdg_suppress, 1);
      idle = $urandom_range(0, 6);
      repeat (idle) step();
      check("R2 random halted", cpu_clk_en, 0);
      case (kind)
        0: irq_pending = 1'b1;
        1: begin ext_wake_en = 1'b1; ext_irq = EXT_N'($urandom_range(1, 15)); end
        2: rtc_irq = 1'b1;
        default: begin rtc_irq = 1'b1; ext_wake_en = 1'b1; ext_irq = 4'b0010; end
      endcase
      step();
      irq_pending = 1'b0; rtc_irq = 1'b0; ext_wake_en = 1'b0; ext_irq = '0;
      check("R5 random wake cpu", cpu_clk_en, 1);
      check("R12 random wake resume", resume_vec, 0);
      if (kind >= 2) begin
        pick = $urandom_range(0, 4);
        case (pick)
          0: j = 0;
          1: j = 1;
          2: j = SHORT - 1;
          3: j = SHORT;
          default: j = $urandom_range(2, SHORT - 2);
        endcase
        for (int e = 1; e <= SHORT; e++) begin
          if (j != 0 && e == j) osc_irq_en = 1'b0;
          if (e == 3) halt_req = 1'b1;
          step();
          halt_req = 1'b0;
          check((j == 0) ? "R6 window cpu" : "R7 late clear cpu",
                cpu_clk_en, win_cpu(e, j, SHORT));
          if (j != 0 && e >= j && e < SHORT)
            check("R7 osc kept", osc_en, 1);
        end
        osc_irq_en = 1'b1;
        step();
        check("R11 halt in window ignored", cpu_clk_en, 1);
      end
    end

    // Deep halt
    osc_irq_en = 1'b0; halt_req = 1'b1; step(); halt_req = 1'b0;
    check("R1 deep entry", osc_en, 0);
    check("R8 deep cpu", cpu_clk_en, 0);
    check("R8 deep periph", periph_clk_en, 0);
    check("R4 deep wdg", wdg_suppress, 0);
    check("R3 deep mask", imask_force_en, 0);
    rtc_irq = 1'b1; irq_pending = 1'b1; ext_irq = 4'b1000; ext_wake_en = 1'b0;
    repeat (4) step();
    check("R8 rtc ignored osc", osc_en, 0);
    check("R8 rtc ignored cpu", cpu_clk_en, 0);
    halt_req = 1'b1; step(); halt_req = 1'b0;
    check("R11 halt in deep", osc_en, 0);
    rtc_irq = 1'b0; irq_pending = 1'b0; long_delay_sel = 1'b1; ext_wake_en = 1'b1;
    step();
    ext_wake_en = 1'b0; ext_irq = '0; long_delay_sel = 1'b0;
    check("R9 deep wake osc", osc_en, 1);
    check("R9 deep wake cpu held", cpu_clk_en, 0);
    count_to_cpu(n);
    check("R9 deep settle long", n, settle_len(1'b1));
    check("R12 deep resume", resume_vec, 0);

    // Reset out of light halt with long delay
    osc_irq_en = 1'b1; halt_req = 1'b1; step(); halt_req = 1'b0;
    long_delay_sel = 1'b1; rst_n = 1'b0; step();
    check("R12 reset resume", resume_vec, 1);
    check("R10 reset cpu", cpu_clk_en, 0);
    rst_n = 1'b1;
    count_to_cpu(n);
    check("R10 boot delay long", n, settle_len(1'b1) + 1);

    summary();
    $finish;
  end
endmodule